// File: doc/BRIEF.md
# Mode-Switched Shared RAM Controller

This block owns an 8-Kbyte static RAM (2048 words of 32 bits) that is shared between a host system bus and two coprocessor engines. In normal mode the host reads and writes the array as plain data memory through a window whose upper address bits come from a programmable base register. When either engine raises its control-store flag, the array becomes microcode storage: the engines read it over their own read ports, possibly both in the same cycle, and every host access to the array is refused.

The block also holds a small register page that the host can always reach. This page carries a low-power stop bit, the array base, a signature result and a status word. The stop bit parks the block in a low-power state. It is not honoured while any engine is in control-store mode, so microcode fetches are never starved. A background signature engine walks the array one word per cycle and folds each word into a 32-bit value that the host reads back and compares against its own figure.

Top module: `shram_ctrl`

## Requirements
- R1: After reset the host sees no acknowledge and no error, `lp_stop` is low, and the base, control and status registers all read 0.
- R2: A host request gives exactly one response one cycle later. A host read of an accepted array word acknowledges with the last value written to that word. A write acknowledges with read data 0.
- R3: While `eng_a_cs` or `eng_b_cs` is high, every host array access gets an error and a refused write leaves the array unchanged. Register-page accesses are still served.
- R4: An engine read issued while that engine's own control-store flag is high returns the addressed word one cycle later. Both engines can read in the same cycle. Otherwise that engine's read data is 0.
- R5: Writing 1 to control bit 0 (STOP) raises `lp_stop` two cycles after the request. While STOP is set, host array accesses get an error. Writing 0 to STOP through the register page restores access.
- R6: A write to the STOP bit made while either control-store flag is high is discarded. `lp_stop` is low in every cycle that follows a cycle with a control-store flag high.
- R7: A host request with `hst_ifetch` high gets an error, whatever address it targets.
- R8: Array words decode at byte address {base[15:0], 3'b000, word[10:0], 2'b00}. Base resets to 0 and is normally programmed to 0xFFA0. An access that is unaligned, or that falls outside both the array and the register page, gets an error.
- R9: An error response lasts one cycle, is never given with an acknowledge, and reads back 0.
- R10: Writing 1 to control bit 1 starts the signature. The register is seeded with 0xFFFFFFFF. Then, for word 0 to 2047 in order, s = {s[30:0],0} ^ (s[31] ? 0x00400007 : 0) ^ word. Status bit 1 (busy) is set during the walk, and status bit 0 (done) is set after the last word. The result reads at register offset 0x8.
- R11: The signature walk pauses while STOP is set or a control-store flag is high. The result register holds still during the pause, and after resuming the final value is the same as an uninterrupted walk.
- R12: The register page sits at upper address 0xFFFA with offsets 0x0 control, 0x4 base (bits 15:0), 0x8 signature (read-only) and 0xC status (bit 0 done, bit 1 busy, bit 2 lp_stop, bit 3 lockout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host request, one cycle per access |
| hst_we | input | 1 | Host write when high, read when low |
| hst_ifetch | input | 1 | Request is tagged as instruction fetch |
| hst_addr | input | 32 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Access accepted (one cycle after request) |
| hst_err | output | 1 | Access refused (one cycle after request) |
| hst_rdata | output | 32 | Host read data, valid with ack |
| eng_a_cs | input | 1 | Engine A control-store mode flag |
| eng_a_rd | input | 1 | Engine A read strobe |
| eng_a_addr | input | 11 | Engine A word address |
| eng_a_rd_data | output | 32 | Engine A read data, one cycle after strobe |
| eng_b_cs | input | 1 | Engine B control-store mode flag |
| eng_b_rd | input | 1 | Engine B read strobe |
| eng_b_addr | input | 11 | Engine B word address |
| eng_b_rd_data | output | 32 | Engine B read data, one cycle after strobe |
| lp_stop | output | 1 | Low-power stop state in effect |

## Verification
The array is filled with a pattern that differs in every word, so a read returned from the wrong address, or a lost write, shows up at once. The signature walk is run over that same pattern twice: once straight through, and once broken by stop and lockout pauses. A matching result shows that no word is skipped or folded twice. Engine reads use different addresses on the two ports in the same cycle, so crossed or shared read paths can be told apart. They are also run with only one flag set, to separate the gating of each port. Refusals are provoked in turn by lockout, stop, an instruction-fetch tag, a stale base and an out-of-range offset, so each refusal condition is shown to act on its own.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam logic [31:0] SIG_TAPS_DEF = 32'h0040_0007;
  localparam logic [31:0] SIG_SEED_DEF = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    RSP_NONE = 3'd0,
    RSP_MEM  = 3'd1,
    RSP_REG  = 3'd2,
    RSP_WACK = 3'd3,
    RSP_ERR  = 3'd4
  } rsp_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BASE = 2'd1,
    REG_SIG  = 2'd2,
    REG_STAT = 2'd3
  } reg_e;
endpackage

// File: rtl/shram_array.sv
module shram_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)   mem[waddr] <= wdata;
    if (a_en) a_q <= mem[a_addr];
    if (b_en) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/shram_sig.sv
module shram_sig #(
  parameter int          ADDR_W = 11,
  parameter int          DATA_W = 32,
  parameter logic [31:0] TAPS   = shram_pkg::SIG_TAPS_DEF,
  parameter logic [31:0] SEED   = shram_pkg::SIG_SEED_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              hold,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_q,
  output logic [DATA_W-1:0] sig,
  output logic              busy,
  output logic              done
);
  logic [ADDR_W-1:0] addr_q;
  logic              run_q, pend_q, last_q, done_q;
  logic [DATA_W-1:0] sig_q;
  logic              at_end;

  assign at_end  = (addr_q == {ADDR_W{1'b1}});
  assign rd_en   = run_q & ~hold;
  assign rd_addr = addr_q;
  assign sig     = sig_q;
  assign busy    = run_q | pend_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      sig_q  <= '0;
    end else if (start) begin
      addr_q <= '0;
      run_q  <= 1'b1;
      pend_q <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      sig_q  <= SEED[DATA_W-1:0];
    end else begin
      pend_q <= rd_en;
      last_q <= rd_en & at_end;
      if (rd_en) begin
        addr_q <= addr_q + 1'b1;
        if (at_end) run_q <= 1'b0;
      end
      if (pend_q) begin
        sig_q <= {sig_q[DATA_W-2:0], 1'b0}
               ^ (sig_q[DATA_W-1] ? TAPS[DATA_W-1:0] : '0)
               ^ rd_q;
        if (last_q) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter int          DATA_W   = 32,
  parameter logic [15:0] BASE_RST = 16'h0000,
  parameter logic [15:0] REG_PAGE = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_req,
  input  logic              hst_we,
  input  logic              hst_ifetch,
  input  logic [31:0]       hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic              hst_ack,
  output logic              hst_err,
  output logic [DATA_W-1:0] hst_rdata,
  input  logic              eng_a_cs,
  input  logic              eng_a_rd,
  input  logic [ADDR_W-1:0] eng_a_addr,
  output logic [DATA_W-1:0] eng_a_rd_data,
  input  logic              eng_b_cs,
  input  logic              eng_b_rd,
  input  logic [ADDR_W-1:0] eng_b_addr,
  output logic [DATA_W-1:0] eng_b_rd_data,
  output logic              lp_stop
);
  localparam int OFF_W = ADDR_W + 2;

  logic              lock;
  logic              stop_q, lp_q;
  logic [15:0]       base_q;
  rsp_e              rsp_q, rsp_d;
  logic [DATA_W-1:0] reg_q, reg_val;
  logic              a_ok_q, b_ok_q;
  logic              arr_hit, reg_hit, arr_ok, reg_ok, sig_start;
  reg_e              reg_sel;

  logic              pa_en, pb_en;
  logic [ADDR_W-1:0] pa_addr, pb_addr;
  logic [DATA_W-1:0] pa_q, pb_q;

  logic              sig_rd, sig_busy, sig_done;
  logic [ADDR_W-1:0] sig_addr;
  logic [DATA_W-1:0] sig_val;

  assign lock    = eng_a_cs | eng_b_cs;
  assign reg_sel = reg_e'(hst_addr[3:2]);
  assign reg_hit = (hst_addr[31:16] == REG_PAGE) && (hst_addr[15:4] == '0)
                 && (hst_addr[1:0] == 2'b00);
  assign arr_hit = (hst_addr[31:16] == base_q) && (hst_addr[15:OFF_W] == '0)
                 && (hst_addr[1:0] == 2'b00) && !reg_hit;
  assign arr_ok  = hst_req & ~hst_ifetch & arr_hit & ~lock & ~stop_q;
  assign reg_ok  = hst_req & ~hst_ifetch & reg_hit;
  assign sig_start = reg_ok & hst_we & (reg_sel == REG_CTRL) & hst_wdata[1];

  always_comb begin
    if (arr_ok)       rsp_d = hst_we ? RSP_WACK : RSP_MEM;
    else if (reg_ok)  rsp_d = hst_we ? RSP_WACK : RSP_REG;
    else if (hst_req) rsp_d = RSP_ERR;
    else              rsp_d = RSP_NONE;
  end

  always_comb begin
    reg_val = '0;
    unique case (reg_sel)
      REG_CTRL: reg_val[0]    = stop_q;
      REG_BASE: reg_val[15:0] = base_q;
      REG_SIG:  reg_val       = sig_val;
      REG_STAT: reg_val[3:0]  = {lock, lp_q, sig_busy, sig_done};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      lp_q   <= 1'b0;
      base_q <= BASE_RST;
      rsp_q  <= RSP_NONE;
      reg_q  <= '0;
      a_ok_q <= 1'b0;
      b_ok_q <= 1'b0;
    end else begin
      rsp_q  <= rsp_d;
      lp_q   <= stop_q & ~lock;
      a_ok_q <= eng_a_rd & eng_a_cs;
      b_ok_q <= eng_b_rd & eng_b_cs;
      if (reg_ok && !hst_we) reg_q <= reg_val;
      if (reg_ok && hst_we) begin
        if (reg_sel == REG_CTRL && !lock) stop_q <= hst_wdata[0];
        if (reg_sel == REG_BASE)          base_q <= hst_wdata[15:0];
      end
    end
  end

  // Port A: host in normal mode, engine A under lockout.
  // Port B: engine B when its flag is set, otherwise the signature walker.
  assign pa_en   = lock ? (eng_a_rd & eng_a_cs) : (arr_ok & ~hst_we);
  assign pa_addr = lock ? eng_a_addr : hst_addr[OFF_W-1:2];
  assign pb_en   = eng_b_cs ? eng_b_rd : sig_rd;
  assign pb_addr = eng_b_cs ? eng_b_addr : sig_addr;

  shram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk    (clk),
    .we     (arr_ok & hst_we),
    .waddr  (hst_addr[OFF_W-1:2]),
    .wdata  (hst_wdata),
    .a_en   (pa_en),
    .a_addr (pa_addr),
    .a_q    (pa_q),
    .b_en   (pb_en),
    .b_addr (pb_addr),
    .b_q    (pb_q)
  );

  shram_sig #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sig (
    .clk     (clk),
    .rst     (rst),
    .start   (sig_start),
    .hold    (stop_q | lock),
    .rd_en   (sig_rd),
    .rd_addr (sig_addr),
    .rd_q    (pb_q),
    .sig     (sig_val),
    .busy    (sig_busy),
    .done    (sig_done)
  );

  assign hst_ack = (rsp_q == RSP_MEM) || (rsp_q == RSP_REG) || (rsp_q == RSP_WACK);
  assign hst_err = (rsp_q == RSP_ERR);

  always_comb begin
    case (rsp_q)
      RSP_MEM: hst_rdata = pa_q;
      RSP_REG: hst_rdata = reg_q;
      default: hst_rdata = '0;
    endcase
  end

  assign eng_a_rd_data = a_ok_q ? pa_q : '0;
  assign eng_b_rd_data = b_ok_q ? pb_q : '0;
  assign lp_stop       = lp_q;
endmodule

// File: rtl/shram_ctrl_chk.sv
module shram_ctrl_chk #(
  parameter int          ADDR_W   = 11,
  parameter int          DATA_W   = 32,
  parameter logic [15:0] REG_PAGE = 16'hFFFA
) (
  input logic              clk,
  input logic              rst,
  input logic              hst_req,
  input logic              hst_ifetch,
  input logic [31:0]       hst_addr,
  input logic              hst_ack,
  input logic              hst_err,
  input logic [DATA_W-1:0] hst_rdata,
  input logic              eng_a_cs,
  input logic              eng_a_rd,
  input logic [DATA_W-1:0] eng_a_rd_data,
  input logic              eng_b_cs,
  input logic              eng_b_rd,
  input logic [DATA_W-1:0] eng_b_rd_data,
  input logic              lp_stop
);
  p_resp_r2: assert property (@(posedge clk) disable iff (rst)
    hst_req |=> (hst_ack || hst_err));

  p_no_resp_r2: assert property (@(posedge clk) disable iff (rst)
    !hst_req |=> (!hst_ack && !hst_err));

  p_lock_refuse_r3: assert property (@(posedge clk) disable iff (rst)
    (hst_req && (eng_a_cs || eng_b_cs) && hst_addr[31:16] != REG_PAGE) |=> hst_err);

  p_gate_a_r4: assert property (@(posedge clk) disable iff (rst)
    !(eng_a_rd && eng_a_cs) |=> (eng_a_rd_data == '0));

  p_gate_b_r4: assert property (@(posedge clk) disable iff (rst)
    !(eng_b_rd && eng_b_cs) |=> (eng_b_rd_data == '0));

  p_stop_held_off_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_a_cs || eng_b_cs) |=> !lp_stop);

  p_ifetch_r7: assert property (@(posedge clk) disable iff (rst)
    (hst_req && hst_ifetch) |=> (hst_err && !hst_ack));

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(hst_ack && hst_err));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    hst_err |-> (hst_rdata == '0));
endmodule

bind shram_ctrl shram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_PAGE(REG_PAGE)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .hst_req       (hst_req),
  .hst_ifetch    (hst_ifetch),
  .hst_addr      (hst_addr),
  .hst_ack       (hst_ack),
  .hst_err       (hst_err),
  .hst_rdata     (hst_rdata),
  .eng_a_cs      (eng_a_cs),
  .eng_a_rd      (eng_a_rd),
  .eng_a_rd_data (eng_a_rd_data),
  .eng_b_cs      (eng_b_cs),
  .eng_b_rd      (eng_b_rd),
  .eng_b_rd_data (eng_b_rd_data),
  .lp_stop       (lp_stop)
);

// File: tb/test_shram_ctrl.sv
`timescale 1ns/1ps
module test_shram_ctrl;
  localparam int          NW   = 2048;
  localparam logic [31:0] ARR  = 32'hFFA0_0000;
  localparam logic [31:0] REGP = 32'hFFFA_0000;
  localparam logic [31:0] TAPS = 32'h0040_0007;

  logic        clk = 1'b0;
  logic        rst;
  logic        hst_req = 0, hst_we = 0, hst_ifetch = 0;
  logic [31:0] hst_addr = '0, hst_wdata = '0;
  logic        hst_ack, hst_err;
  logic [31:0] hst_rdata;
  logic        eng_a_cs = 0, eng_a_rd = 0, eng_b_cs = 0, eng_b_rd = 0;
  logic [10:0] eng_a_addr = '0, eng_b_addr = '0;
  logic [31:0] eng_a_rd_data, eng_b_rd_data;
  logic        lp_stop;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] model [NW];
  logic [31:0] exp_sig;

  always #2.5 clk = ~clk;

  shram_ctrl i_shram_ctrl (
    .clk(clk), .rst(rst),
    .hst_req(hst_req), .hst_we(hst_we), .hst_ifetch(hst_ifetch),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_ack(hst_ack), .hst_err(hst_err), .hst_rdata(hst_rdata),
    .eng_a_cs(eng_a_cs), .eng_a_rd(eng_a_rd), .eng_a_addr(eng_a_addr),
    .eng_a_rd_data(eng_a_rd_data),
    .eng_b_cs(eng_b_cs), .eng_b_rd(eng_b_rd), .eng_b_addr(eng_b_addr),
    .eng_b_rd_data(eng_b_rd_data),
    .lp_stop(lp_stop)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic host(input bit we, input bit ifetch, input logic [31:0] addr,
                      input logic [31:0] wdata, output logic [31:0] rd,
                      output logic ack, output logic err);
    @(negedge clk);
    hst_req = 1; hst_we = we; hst_ifetch = ifetch; hst_addr = addr; hst_wdata = wdata;
    @(negedge clk);
    hst_req = 0; hst_we = 0; hst_ifetch = 0;
    rd = hst_rdata; ack = hst_ack; err = hst_err;
  endtask

  // Expect an accepted read with given data.
  task automatic rd_ok(input logic [31:0] addr, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic ack, err;
    host(0, 0, addr, '0, rd, ack, err);
    check(ack && !err && rd == exp, req, rd, exp);
  endtask

  task automatic wr_ok(input logic [31:0] addr, input logic [31:0] d, input string req);
    logic [31:0] rd; logic ack, err;
    host(1, 0, addr, d, rd, ack, err);
    check(ack && !err && rd == 0, req, {ack, err, rd[29:0]}, 32'h8000_0000);
  endtask

  task automatic acc_err(input bit we, input bit ifetch, input logic [31:0] addr,
                         input string req);
    logic [31:0] rd; logic ack, err;
    host(we, ifetch, addr, 32'hDEAD_BEEF, rd, ack, err);
    check(err && !ack && rd == 0, req, {ack, err, rd[29:0]}, 32'h4000_0000);
    @(negedge clk);
    check(!hst_err, {req, " single-cycle error (R9)"}, {31'd0, hst_err}, 32'd0);
  endtask

  task automatic t_reset;
    check(!hst_ack && !hst_err && !lp_stop, "R1 idle outputs",
          {29'd0, hst_ack, hst_err, lp_stop}, 32'd0);
    rd_ok(REGP + 32'h4, 32'd0, "R1 base reset");
    rd_ok(REGP + 32'h0, 32'd0, "R1 control reset");
    rd_ok(REGP + 32'hC, 32'd0, "R1 status reset");
  endtask

  task automatic t_base;
    wr_ok(REGP + 32'h4, 32'h0000_FFA0, "R12 base write");
    rd_ok(REGP + 32'h4, 32'h0000_FFA0, "R12 base readback");
    acc_err(0, 0, 32'h0000_0010, "R8 old page refused");
    acc_err(0, 0, ARR + 32'h2000, "R8 beyond 8K refused");
    acc_err(0, 0, ARR + 32'h2, "R8 unaligned refused");
    acc_err(0, 0, REGP + 32'h10, "R8 past register page refused");
  endtask

  task automatic t_fill;
    for (int i = 0; i < NW; i++) begin
      logic [31:0] rd; logic ack, err;
      model[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F ^ (i << 20);
      host(1, 0, ARR + i * 4, model[i], rd, ack, err);
      if (i == 0 || i == NW - 1)
        check(ack && !err, "R2 write ack", {30'd0, ack, err}, 32'd2);
    end
    rd_ok(ARR + 0, model[0], "R2 read word 0");
    rd_ok(ARR + 4, model[1], "R2 read word 1");
    rd_ok(ARR + 1000 * 4, model[1000], "R2 read word 1000");
    rd_ok(ARR + (NW - 1) * 4, model[NW - 1], "R2 read last word");
  endtask

  task automatic t_ifetch;
    acc_err(0, 1, ARR + 8, "R7 ifetch array");
    acc_err(0, 1, REGP + 32'h4, "R7 ifetch register");
  endtask

  task automatic eng_read(input bit ra, input logic [10:0] aa, input bit rb,
                          input logic [10:0] ab);
    @(negedge clk);
    eng_a_rd = ra; eng_a_addr = aa; eng_b_rd = rb; eng_b_addr = ab;
    @(negedge clk);
    eng_a_rd = 0; eng_b_rd = 0;
  endtask

  task automatic t_lock;
    @(negedge clk); eng_a_cs = 1;
    acc_err(0, 0, ARR + 5 * 4, "R3 read refused under lockout");
    acc_err(1, 0, ARR + 5 * 4, "R3 write refused under lockout");
    rd_ok(REGP + 32'hC, 32'h8, "R3 register page open, R12 lockout bit");
    eng_read(1, 11'd7, 1, 11'd9);
    check(eng_a_rd_data == model[7], "R4 engine A read", eng_a_rd_data, model[7]);
    check(eng_b_rd_data == 0, "R4 engine B gated off", eng_b_rd_data, 32'd0);
    @(negedge clk); eng_b_cs = 1; eng_a_cs = 0;
    acc_err(0, 0, ARR + 12, "R3 refused with engine B flag");
    eng_read(1, 11'd3, 1, 11'd2047);
    check(eng_a_rd_data == 0, "R4 engine A gated off", eng_a_rd_data, 32'd0);
    check(eng_b_rd_data == model[2047], "R4 engine B read", eng_b_rd_data, model[2047]);
    @(negedge clk); eng_a_cs = 1;
    eng_read(1, 11'd100, 1, 11'd1500);
    check(eng_a_rd_data == model[100], "R4 simultaneous A", eng_a_rd_data, model[100]);
    check(eng_b_rd_data == model[1500], "R4 simultaneous B", eng_b_rd_data, model[1500]);
    @(negedge clk); eng_a_cs = 0; eng_b_cs = 0;
    rd_ok(ARR + 5 * 4, model[5], "R3 refused write left word unchanged");
  endtask

  task automatic t_stop;
    wr_ok(REGP, 32'h1, "R5 set STOP");
    check(!lp_stop, "R5 lp_stop not yet", {31'd0, lp_stop}, 32'd0);
    @(negedge clk);
    check(lp_stop, "R5 lp_stop raised", {31'd0, lp_stop}, 32'd1);
    acc_err(0, 0, ARR + 16, "R5 array refused in stop");
    rd_ok(REGP, 32'h1, "R5 control readable in stop");
    wr_ok(REGP, 32'h0, "R5 clear STOP");
    rd_ok(ARR + 16, model[4], "R5 array served after clear");
    check(!lp_stop, "R5 lp_stop dropped", {31'd0, lp_stop}, 32'd0);
  endtask

  task automatic t_stop_lock;
    @(negedge clk); eng_b_cs = 1;
    wr_ok(REGP, 32'h1, "R6 STOP write under lockout acked");
    rd_ok(REGP, 32'h0, "R6 STOP write discarded");
    @(negedge clk); eng_b_cs = 0;
    @(negedge clk); @(negedge clk);
    check(!lp_stop, "R6 no stop after lockout ends", {31'd0, lp_stop}, 32'd0);
    wr_ok(REGP, 32'h1, "R6 set STOP");
    @(negedge clk);
    eng_a_cs = 1;
    @(negedge clk);
    check(!lp_stop, "R6 stop held off by lockout", {31'd0, lp_stop}, 32'd0);
    wr_ok(REGP, 32'h0, "R6 clear attempt under lockout");
    eng_a_cs = 0;
    @(negedge clk);
    check(lp_stop, "R6 stop resumes after lockout", {31'd0, lp_stop}, 32'd1);
    wr_ok(REGP, 32'h0, "R6 clear STOP");
  endtask

  task automatic wait_done(input string req);
    logic [31:0] rd; logic ack, err;
    int n = 0;
    do begin
      host(0, 0, REGP + 32'hC, '0, rd, ack, err);
      n++;
    end while (!rd[0] && n < 4000);
    check(rd[0] && !rd[1], req, rd, 32'h1);
  endtask

  task automatic t_sig;
    exp_sig = 32'hFFFF_FFFF;
    for (int i = 0; i < NW; i++)
      exp_sig = {exp_sig[30:0], 1'b0} ^ (exp_sig[31] ? TAPS : 32'd0) ^ model[i];
    wr_ok(REGP, 32'h2, "R10 start");
    rd_ok(REGP + 32'hC, 32'h2, "R10 busy after start");
    wait_done("R10 done flag");
    rd_ok(REGP + 32'h8, exp_sig, "R10 signature value");
  endtask

  task automatic t_sig_pause;
    logic [31:0] s1, s2; logic ack, err;
    wr_ok(REGP, 32'h2, "R11 start");
    repeat (300) @(negedge clk);
    wr_ok(REGP, 32'h1, "R11 stop");
    repeat (3) @(negedge clk);
    host(0, 0, REGP + 32'h8, '0, s1, ack, err);
    repeat (100) @(negedge clk);
    host(0, 0, REGP + 32'h8, '0, s2, ack, err);
    check(s1 == s2, "R11 held in stop", s2, s1);
    rd_ok(REGP + 32'hC, 32'h6, "R11 busy in stop");
    wr_ok(REGP, 32'h0, "R11 clear stop");
    repeat (300) @(negedge clk);
    eng_a_cs = 1;
    repeat (3) @(negedge clk);
    host(0, 0, REGP + 32'h8, '0, s1, ack, err);
    repeat (150) @(negedge clk);
    host(0, 0, REGP + 32'h8, '0, s2, ack, err);
    check(s1 == s2, "R11 held in lockout", s2, s1);
    eng_a_cs = 0;
    wait_done("R11 done after pauses");
    rd_ok(REGP + 32'h8, exp_sig, "R11 signature matches");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_base();
    t_fill();
    t_ifetch();
    t_lock();
    t_stop();
    t_stop_lock();
    t_sig();
    t_sig_pause();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule